// File: doc/BRIEF.md
# Three-Level Page-Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a three-level page table in memory. The caller hands it a request: the virtual address, the physical page number of the root table, the kind of access (load, store, atomic read-modify-write or instruction fetch), the privilege of the access and two relaxation flags. The walker then reads one 8-byte table entry per level over a request/response memory port.

A pointer entry sends the walk one level down. A leaf entry is checked against the access rules and, at levels 2 and 1, against superpage alignment. On success the walker returns the physical address, the raw leaf entry, the physical address of that entry, the level at which the walk ended, and a global flag collected along the path. On failure it returns an error code.

Setting accessed or dirty bits, and filling a translation cache, are left to the caller. The caller uses the returned entry and entry address for that work.

Top module: `pt_walker3`

## Requirements
- R1: `reqReady` is high exactly when the walker is idle, which includes the state right after reset. A request is taken only when `reqValid` and `reqReady` are both high. A `reqValid` pulse during a walk is ignored: it does not change the entries read or the result, and it starts no later walk.
- R2: The first entry read is at level 2 from the root page number. Every entry address equals (table page number × 4096) + (the 9-bit slice of the virtual address for that level × 8). Level L uses address bits [12+9L+8 : 12+9L].
- R3: An entry with V=1 and R=W=X=0 is a pointer. At level 2 or level 1 it continues the walk one level lower, with entry bits [53:10] as the next table page number. At level 0 it ends the walk with code 2.
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with code 2. The attribute bits are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, G=bit5.
- R5: For a leaf, a load needs R=1, or X=1 together with `reqMxr`=1. A store needs W=1. An atomic access needs both the load rule and the store rule. A fetch needs X=1. For a user access (`reqUser`=1) the leaf must also have U=1. For a supervisor access, loads, stores and atomics need U=0 or `reqSum`=1, and fetches need U=0. A leaf that breaks these rules gives code 3.
- R6: A leaf at level L>0 that passes the R5 rules gives code 4 if any of the low 9·L bits of its page number is nonzero. The R5 check takes priority over this one.
- R7: On success (code 0) the physical address is the leaf page number with its low 9·L bits taken from virtual address bits [12+9L-1:12], followed by the 12-bit page offset. `donePte` is the leaf, `donePteAddr` is the leaf's address, and `doneLevel` is L.
- R8: `doneGlobal` is the OR of the G bits of every entry read during the walk.
- R9: A memory response with `memRspErr`=1 ends the walk at once with code 1, and no further entry is read.
- R10: `doneValid` is high for exactly one cycle per walk. The cycle after it, the walker is idle again. Code 5 (update needed) is reserved for the caller and is never produced by the walker.
- R11: `memReqValid` stays high with a stable address until `memReqReady` is seen. Only one read is outstanding at a time. The walker waits for `memRspValid` before it acts on an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request strobe |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 39 | Virtual address to translate |
| reqRootPpn | input | 44 | Page number of the root table |
| reqAccess | input | 2 | 0 load, 1 store, 2 atomic, 3 fetch |
| reqUser | input | 1 | 1 user access, 0 supervisor access |
| reqMxr | input | 1 | Execute-only pages readable by loads |
| reqSum | input | 1 | Supervisor may touch user pages (not fetch) |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 56 | Physical address of the entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read from memory |
| memRspErr | input | 1 | Read failed |
| doneValid | output | 1 | Result valid, one cycle |
| doneErr | output | 3 | 0 ok, 1 memory fault, 2 bad entry, 3 denied, 4 misaligned superpage, 5 update needed |
| donePaddr | output | 56 | Translated physical address |
| donePte | output | 64 | Leaf entry |
| donePteAddr | output | 56 | Address of the leaf entry |
| doneLevel | output | 2 | Level at which the walk ended |
| doneGlobal | output | 1 | OR of G bits along the path |

## Verification
The assertions check the following on every cycle:
- the ready, request and result strobes exclude each other;
- the result pulse lasts a single cycle;
- a memory request is held until accepted;
- the level drops by one on each descent and the walk starts at level 2;
- the global flag is sticky;
- a misaligned code only comes from a superpage;
- a successful result keeps the page offset.

Only the bench scenarios can show the rest, because they need a page table in memory:
- the order of entry addresses;
- the permission matrix, including the relaxation flags;
- superpage address assembly;
- priority of the permission check over alignment;
- fault termination;
- that a request made mid-walk is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int PAGE_BITS  = 12;
  parameter int LEVEL_BITS = 9;
  parameter int LEVELS     = 3;
  parameter int PPN_BITS   = 44;
  parameter int PTE_BITS   = 64;
  parameter int PTE_PPN_LSB = 10;
  parameter int PTE_BYTES_LOG = 3;
  localparam int VA_BITS  = PAGE_BITS + LEVELS * LEVEL_BITS;
  localparam int PA_BITS  = PPN_BITS + PAGE_BITS;
  localparam int VPN_BITS = LEVELS * LEVEL_BITS;
  localparam int LVL_W    = $clog2(LEVELS);

  localparam int ATTR_V = 0;
  localparam int ATTR_R = 1;
  localparam int ATTR_W = 2;
  localparam int ATTR_X = 3;
  localparam int ATTR_U = 4;
  localparam int ATTR_G = 5;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_MEM = 3'd1, ERR_BAD_ENTRY = 3'd2,
    ERR_DENIED = 3'd3, ERR_SUPER_ALIGN = 3'd4, ERR_NEEDS_UPDATE = 3'd5
  } walkErr_e;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_AMO = 2'd2, ACC_FETCH = 2'd3
  } access_e;

  typedef struct packed {
    logic load;
    logic descend;
    logic finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [7:0] attr,
  input  access_e    acc,
  input  logic       user,
  input  logic       mxr,
  input  logic       sum,
  output logic       allow
);
  logic readable, writable, userPage, dataReach, kindOk;

  always_comb begin
    readable  = attr[ATTR_R] | (attr[ATTR_X] & mxr);
    writable  = attr[ATTR_W];
    userPage  = attr[ATTR_U];
    dataReach = user ? userPage : (!userPage | sum);
    unique case (acc)
      ACC_LOAD:  kindOk = readable & dataReach;
      ACC_STORE: kindOk = writable & dataReach;
      ACC_AMO:   kindOk = readable & writable & dataReach;
      default:   kindOk = attr[ATTR_X] & (user ? userPage : !userPage);
    endcase
    allow = kindOk;
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        goDeeper,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneValid
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    strobe.load    = (state == S_IDLE) && reqValid;
    strobe.descend = (state == S_WAIT) && memRspValid && goDeeper;
    strobe.finish  = (state == S_WAIT) && memRspValid && !goDeeper;
    stateNext = state;
    unique case (state)
      S_IDLE:  if (reqValid) stateNext = S_ISSUE;
      S_ISSUE: if (memReqReady) stateNext = S_WAIT;
      S_WAIT:  if (memRspValid) stateNext = goDeeper ? S_ISSUE : S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign doneValid   = (state == S_DONE);

  p_idle_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !doneValid));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
  p_no_req_while_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !memReqValid);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [VA_BITS-1:0]  reqVaddr,
  input  logic [PPN_BITS-1:0] reqRootPpn,
  input  access_e             reqAccess,
  input  logic                reqUser,
  input  logic                reqMxr,
  input  logic                reqSum,
  input  logic [PTE_BITS-1:0] memRspData,
  input  logic                memRspErr,
  output logic                goDeeper,
  output logic [PA_BITS-1:0]  memReqAddr,
  output walkErr_e            doneErr,
  output logic [PA_BITS-1:0]  donePaddr,
  output logic [PTE_BITS-1:0] donePte,
  output logic [PA_BITS-1:0]  donePteAddr,
  output logic [LVL_W-1:0]    doneLevel,
  output logic                doneGlobal
);
  logic [VA_BITS-1:0]    vaQ;
  access_e               accQ;
  logic                  userQ, mxrQ, sumQ, globalQ;
  logic [PPN_BITS-1:0]   baseQ;
  logic [LVL_W-1:0]      levelQ;

  logic [LEVEL_BITS-1:0] slice;
  logic [PA_BITS-1:0]    entryAddr;
  logic [7:0]            attr;
  logic [PPN_BITS-1:0]   leafPpn, lowMask, vpnExt, finalPpn;
  logic                  isInvalid, isPtr, misaligned, allow;
  walkErr_e              code;

  ptw_perm uPerm (
    .attr(attr), .acc(accQ), .user(userQ), .mxr(mxrQ), .sum(sumQ), .allow(allow)
  );

  always_comb begin
    slice     = vaQ[PAGE_BITS + 32'(levelQ) * LEVEL_BITS +: LEVEL_BITS];
    entryAddr = {baseQ, {PAGE_BITS{1'b0}}}
              + PA_BITS'({slice, {PTE_BYTES_LOG{1'b0}}});
    attr      = memRspData[7:0];
    leafPpn   = memRspData[PTE_PPN_LSB +: PPN_BITS];
    lowMask   = (PPN_BITS'(1) << (32'(levelQ) * LEVEL_BITS)) - PPN_BITS'(1);
    vpnExt    = PPN_BITS'(vaQ[VA_BITS-1:PAGE_BITS]);
    finalPpn  = leafPpn | (vpnExt & lowMask);
    isInvalid = !attr[ATTR_V] || (attr[ATTR_W] && !attr[ATTR_R]);
    isPtr     = !attr[ATTR_R] && !attr[ATTR_W] && !attr[ATTR_X];
    misaligned = |(leafPpn & lowMask);
    goDeeper  = !memRspErr && !isInvalid && isPtr && (levelQ != '0);
    if (memRspErr)      code = ERR_MEM;
    else if (isInvalid) code = ERR_BAD_ENTRY;
    else if (isPtr)     code = ERR_BAD_ENTRY;
    else if (!allow)    code = ERR_DENIED;
    else if (misaligned) code = ERR_SUPER_ALIGN;
    else                code = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; accQ <= ACC_LOAD; userQ <= 1'b0; mxrQ <= 1'b0; sumQ <= 1'b0;
      baseQ <= '0; levelQ <= '0; globalQ <= 1'b0;
      doneErr <= ERR_NONE; donePaddr <= '0; donePte <= '0;
      donePteAddr <= '0; doneGlobal <= 1'b0;
    end else begin
      if (strobe.load) begin
        vaQ <= reqVaddr; accQ <= reqAccess; userQ <= reqUser;
        mxrQ <= reqMxr; sumQ <= reqSum;
        baseQ <= reqRootPpn;
        levelQ <= LVL_W'(LEVELS - 1);
        globalQ <= 1'b0;
      end
      if (strobe.descend) begin
        baseQ   <= leafPpn;
        levelQ  <= levelQ - LVL_W'(1);
        globalQ <= globalQ | attr[ATTR_G];
      end
      if (strobe.finish) begin
        doneErr     <= code;
        donePaddr   <= {finalPpn, vaQ[PAGE_BITS-1:0]};
        donePte     <= memRspData;
        donePteAddr <= entryAddr;
        doneGlobal  <= globalQ | (!memRspErr && attr[ATTR_G]);
      end
    end
  end

  assign memReqAddr = entryAddr;
  assign doneLevel  = levelQ;

  p_start_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (levelQ == LVL_W'(LEVELS - 1)));
  p_descend_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.descend |=> (levelQ == $past(levelQ) - LVL_W'(1)));
  p_global_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.descend && globalQ) |=> globalQ);
  p_super_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && code == ERR_SUPER_ALIGN) |-> (levelQ != '0));
  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && code == ERR_NONE) |=>
      (donePaddr[PAGE_BITS-1:0] == vaQ[PAGE_BITS-1:0]));
endmodule

// File: rtl/pt_walker3.sv
module pt_walker3
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_BITS-1:0]  reqVaddr,
  input  logic [PPN_BITS-1:0] reqRootPpn,
  input  logic [1:0]          reqAccess,
  input  logic                reqUser,
  input  logic                reqMxr,
  input  logic                reqSum,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [PA_BITS-1:0]  memReqAddr,
  input  logic                memRspValid,
  input  logic [PTE_BITS-1:0] memRspData,
  input  logic                memRspErr,
  output logic                doneValid,
  output logic [2:0]          doneErr,
  output logic [PA_BITS-1:0]  donePaddr,
  output logic [PTE_BITS-1:0] donePte,
  output logic [PA_BITS-1:0]  donePteAddr,
  output logic [LVL_W-1:0]    doneLevel,
  output logic                doneGlobal
);
  ctrlStrobe_t strobe;
  logic        goDeeper;
  walkErr_e    errCode;

  ptw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .goDeeper(goDeeper), .strobe(strobe),
    .reqReady(reqReady), .memReqValid(memReqValid), .doneValid(doneValid)
  );

  ptw_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqRootPpn(reqRootPpn), .reqAccess(access_e'(reqAccess)), .reqUser(reqUser),
    .reqMxr(reqMxr), .reqSum(reqSum), .memRspData(memRspData),
    .memRspErr(memRspErr), .goDeeper(goDeeper), .memReqAddr(memReqAddr),
    .doneErr(errCode), .donePaddr(donePaddr), .donePte(donePte),
    .donePteAddr(donePteAddr), .doneLevel(doneLevel), .doneGlobal(doneGlobal)
  );

  assign doneErr = errCode;
endmodule

// File: tb/tb_pt_walker3.sv
module tb_pt_walker3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [38:0] reqVaddr = '0;
  logic [43:0] reqRootPpn = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0, reqMxr = 1'b0, reqSum = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [55:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        doneValid;
  logic [2:0]  doneErr;
  logic [55:0] donePaddr, donePteAddr;
  logic [63:0] donePte;
  logic [1:0]  doneLevel;
  logic        doneGlobal;

  always #5 clk = ~clk;

  pt_walker3 dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqRootPpn(reqRootPpn), .reqAccess(reqAccess),
    .reqUser(reqUser), .reqMxr(reqMxr), .reqSum(reqSum),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .doneValid(doneValid), .doneErr(doneErr), .donePaddr(donePaddr),
    .donePte(donePte), .donePteAddr(donePteAddr), .doneLevel(doneLevel),
    .doneGlobal(doneGlobal)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] mem [logic [55:0]];
  bit          errMap [logic [55:0]];

  logic [55:0] expAddrQ [$];
  int          expErr, expLevel;
  logic [55:0] expPaddr, expPteAddr;
  logic [63:0] expPte;
  bit          expGlobal;

  localparam logic [7:0] AV = 8'h01, AR = 8'h02, AW = 8'h04, AX = 8'h08,
                         AU = 8'h10, AG = 8'h20, AA = 8'h40, AD = 8'h80;
  localparam logic [43:0] ROOT = 44'h80;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] entryAt(logic [43:0] base, logic [38:0] va, int lvl);
    logic [8:0] s;
    s = va[12 + 9*lvl +: 9];
    return {base, 12'h000} + {44'h0, s, 3'b000};
  endfunction

  function automatic logic [63:0] pteOf(logic [43:0] ppn, logic [7:0] at);
    return {10'h000, ppn, 2'b00, at};
  endfunction

  function automatic bit permOk(logic [7:0] at, int acc, bit user, bit mxr, bit sum);
    bit rd, reach;
    rd = at[1] || (at[3] && mxr);
    if (user) reach = at[4];
    else if (acc == 3) reach = !at[4];
    else reach = !at[4] || sum;
    if (!reach) return 0;
    if (acc == 0) return rd;
    if (acc == 1) return at[2];
    if (acc == 2) return rd && at[2];
    return at[3];
  endfunction

  task automatic refWalk(input logic [38:0] va, input logic [43:0] root,
                         input int acc, input bit user, input bit mxr, input bit sum);
    logic [43:0] base, ppn, mask;
    logic [55:0] a;
    logic [63:0] d;
    logic [7:0]  at;
    bit g;
    base = root; g = 0;
    expAddrQ.delete();
    for (int l = 2; l >= 0; l--) begin
      a = entryAt(base, va, l);
      expAddrQ.push_back(a);
      if (errMap.exists(a)) begin expErr = 1; return; end
      d = mem.exists(a) ? mem[a] : 64'h0;
      at = d[7:0];
      g = g | at[5];
      if (!at[0] || (at[2] && !at[1])) begin expErr = 2; return; end
      ppn = d[53:10];
      if (at[3:1] == 3'b000) begin
        if (l == 0) begin expErr = 2; return; end
        base = ppn;
        continue;
      end
      if (!permOk(at, acc, user, mxr, sum)) begin expErr = 3; return; end
      mask = (44'd1 << (9*l)) - 44'd1;
      if ((ppn & mask) != 0) begin expErr = 4; return; end
      expErr = 0;
      expPaddr = {ppn | ({17'h0, va[38:12]} & mask), va[11:0]};
      expPte = d; expPteAddr = a; expLevel = l; expGlobal = g;
      return;
    end
  endtask

  // Pointers from ROOT down to lvl, tables at ROOT+1 and ROOT+2, then the leaf.
  task automatic buildPath(input logic [38:0] va, input int lvl, input logic [63:0] leaf);
    logic [43:0] base;
    base = ROOT;
    mem.delete(); errMap.delete();
    for (int l = 2; l > lvl; l--) begin
      mem[entryAt(base, va, l)] = pteOf(base + 44'd1, AV);
      base = base + 44'd1;
    end
    mem[entryAt(base, va, lvl)] = leaf;
  endtask

  task automatic runWalk(input string tag, input logic [38:0] va, input int acc,
                         input bit user, input bit mxr, input bit sum, input bit inject);
    int cyc, delay;
    bit pending, done;
    logic [55:0] heldAddr;
    refWalk(va, ROOT, acc, user, mxr, sum);
    @(negedge clk);
    chk(reqReady === 1'b1, "R1 idle before request", reqReady, 1);
    reqValid = 1; reqVaddr = va; reqRootPpn = ROOT; reqAccess = 2'(acc);
    reqUser = user; reqMxr = mxr; reqSum = sum;
    @(negedge clk);
    reqValid = 0;
    pending = 0; done = 0; delay = 0; cyc = 0;
    while (!done && cyc < 300) begin
      cyc++;
      memRspValid = 0; memRspErr = 0;
      if (inject && cyc == 2) begin
        reqValid = 1; reqVaddr = ~va; reqAccess = 2'd3;
      end else reqValid = 0;
      if (doneValid) begin
        done = 1;
        chk(doneErr == 3'(expErr), {tag, " code"}, doneErr, expErr);
        if (expErr == 0) begin
          chk(donePaddr == expPaddr, {tag, " R7 paddr"}, donePaddr, expPaddr);
          chk(donePte == expPte, {tag, " R7 pte"}, donePte, expPte);
          chk(donePteAddr == expPteAddr, {tag, " R7 pte addr"}, donePteAddr, expPteAddr);
          chk(doneLevel == 2'(expLevel), {tag, " R7 level"}, doneLevel, expLevel);
          chk(doneGlobal == expGlobal, {tag, " R8 global"}, doneGlobal, expGlobal);
        end
      end else begin
        chk(reqReady === 1'b0, {tag, " R1 busy not ready"}, reqReady, 0);
        if (memReqValid) begin
          if (memReqReady) begin
            chk(memReqAddr == heldAddr, {tag, " R11 held address"}, memReqAddr, heldAddr);
          end
          heldAddr = memReqAddr;
          memReqReady = 1'($urandom % 2);
          if (memReqReady) begin
            if (expAddrQ.size() == 0) begin
              chk(0, {tag, " R2 unexpected read"}, memReqAddr, 0);
            end else begin
              chk(memReqAddr == expAddrQ[0], {tag, " R2 entry address"},
                  memReqAddr, expAddrQ[0]);
              void'(expAddrQ.pop_front());
            end
            pending = 1; delay = $urandom % 3;
          end
        end else begin
          memReqReady = 0;
          if (pending) begin
            if (delay == 0) begin
              memRspValid = 1;
              memRspErr = errMap.exists(heldAddr);
              memRspData = mem.exists(heldAddr) ? mem[heldAddr] : 64'h0;
              pending = 0;
            end else delay--;
          end
        end
      end
      @(negedge clk);
    end
    memReqReady = 0; memRspValid = 0; memRspErr = 0; reqValid = 0;
    chk(done, {tag, " R10 walk completed"}, done, 1);
    chk(expAddrQ.size() == 0, {tag, " R9 R2 all reads made"}, expAddrQ.size(), 0);
    chk(!doneValid && reqReady, {tag, " R10 single pulse then idle"}, doneValid, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!memReqValid, {tag, " R1 no stray walk"}, memReqValid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [38:0] va;
    logic [55:0] a1;
    va = {9'h0A5, 9'h13C, 9'h07F, 12'hABC};
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1, "R1 reset ready", reqReady, 1);
    chk(memReqValid === 1'b0, "R11 reset no request", memReqValid, 0);
    chk(doneValid === 1'b0, "R10 reset no result", doneValid, 0);
    rstN = 1;

    // R2 R3 R7 R8: 4K page, G on the level-1 pointer
    buildPath(va, 0, pteOf(44'h12345, AV|AR|AW|AA|AD));
    mem[entryAt(ROOT + 44'd1, va, 1)] = pteOf(ROOT + 44'd2, AV|AG);
    runWalk("R7 R8 4K global path", va, 0, 0, 0, 0, 0);
    // R1: request pulse mid-walk ignored
    runWalk("R1 injected request", va, 0, 0, 0, 0, 1);
    // R7: 1G superpage
    buildPath(va, 2, pteOf(44'h40000, AV|AR|AU));
    runWalk("R7 1G superpage", va, 0, 1, 0, 0, 0);
    // R7 R8: 2M superpage with G on leaf
    buildPath(va, 1, pteOf(44'h1200, AV|AR|AW|AG));
    runWalk("R7 R8 2M superpage", va, 1, 0, 0, 0, 0);
    // R6: misaligned, then denied takes priority
    buildPath(va, 1, pteOf(44'h1201, AV|AR|AW));
    runWalk("R6 misaligned 2M", va, 0, 0, 0, 0, 0);
    runWalk("R6 R5 denied before align", va, 0, 1, 0, 0, 0);
    buildPath(va, 2, pteOf(44'h40100, AV|AX));
    runWalk("R6 misaligned 1G", va, 3, 0, 0, 0, 0);
    // R3: pointer at level 0
    buildPath(va, 0, pteOf(44'h90, AV));
    runWalk("R3 pointer at leaf level", va, 0, 0, 0, 0, 0);
    // R4: invalid entries
    buildPath(va, 0, pteOf(44'h90, AR|AW));
    runWalk("R4 not valid", va, 0, 0, 0, 0, 0);
    buildPath(va, 1, pteOf(44'h1200, AV|AW));
    runWalk("R4 write without read", va, 1, 0, 0, 0, 0);
    // R5: permission matrix
    buildPath(va, 0, pteOf(44'h777, AV|AR));
    runWalk("R5 user on supervisor page", va, 0, 1, 0, 0, 0);
    runWalk("R5 store to read-only", va, 1, 0, 0, 0, 0);
    buildPath(va, 0, pteOf(44'h777, AV|AR|AW|AU|AX));
    runWalk("R5 supervisor on user page no sum", va, 0, 0, 0, 0, 0);
    runWalk("R5 supervisor on user page with sum", va, 2, 0, 0, 1, 0);
    runWalk("R5 supervisor fetch user page", va, 3, 0, 0, 1, 0);
    runWalk("R5 user fetch", va, 3, 1, 0, 0, 0);
    runWalk("R5 user atomic", va, 2, 1, 0, 0, 0);
    buildPath(va, 0, pteOf(44'h777, AV|AX));
    runWalk("R5 exec-only load no mxr", va, 0, 0, 0, 0, 0);
    runWalk("R5 exec-only load with mxr", va, 0, 0, 1, 0, 0);
    // R9: memory fault at level 1
    buildPath(va, 0, pteOf(44'h12345, AV|AR));
    a1 = entryAt(ROOT + 44'd1, va, 1);
    errMap[a1] = 1;
    runWalk("R9 fault at level 1", va, 0, 0, 0, 0, 0);
    errMap.delete();
    errMap[entryAt(ROOT, va, 2)] = 1;
    runWalk("R9 fault at root", va, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule